// File: doc/BRIEF.md
# Inter-Processor Doorbell Router

This block carries doorbell messages between the cores of a multi-core cluster. Each core has its own command port. On one port a core can either send a doorbell message or clear a doorbell. A send reaches every core whose identity register matches the tag in the message, or every core when the message asks for broadcast. Each core that a send reaches gets its normal or critical doorbell pending bit set, and one interrupt notification pulse is raised toward that core. A clear acts only on the issuing core. It drops that core's pending bit for the doorbell kind named in the message.

The message word is 32 bits wide. Bits [31:27] hold the kind code, bit 26 is the broadcast flag, and bits [13:0] carry the target identity tag. Bits [25:14] are not used. Only kind codes 0 (normal) and 1 (critical) cause any action. The guest kinds 2, 3 and 4, and all other codes, are dropped without effect.

Each core's identity register can be rewritten through a simple write port. There is no sequencing state machine. Every core slot holds two pending bits, and each bit has two states, idle and pending. A bit moves from idle to pending when a matching send arrives. It moves from pending to idle on a matching clear from its own core, but only when no send hits it in the same cycle. Otherwise the bit stays where it is.

Top module: `db_router`

## Requirements
- R1: After reset, all pending bits and notify pulses are 0, and core t's identity register holds the value t.
- R2: A send with kind code 0 in bits [31:27] sets the normal pending bit of each targeted core. A send with kind code 1 sets the critical pending bit instead. The bit reads set on the cycle after the command is accepted.
- R3: A send with bit 26 set targets every core, whatever its tag.
- R4: A send with bit 26 clear targets only the cores whose identity equals bits [13:0]. Cores that are not targeted keep their pending bits unchanged.
- R5: Each targeted core sees its notify output high for exactly one cycle, in the same cycle its pending bit first reads set. Cores that are not targeted see no notify.
- R6: A clear drops only the pending bit of the decoded kind, and only on the issuing core. The broadcast flag and the tag of a clear are ignored.
- R7: Kind codes 2 to 31 have no effect on send or clear: no pending bit changes and no notify is raised.
- R8: A write on the identity port changes that core's identity from the next cycle on. Later sends are steered by the new value.
- R9: When a send and a clear hit the same pending bit of one core in the same cycle, the bit ends up set.
- R10: Sends from several cores in the same cycle combine. Every core targeted by any of them is updated and notified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cmd_valid | input | NUM_CORES | Per-core command strobe |
| cmd_clear | input | NUM_CORES | Per-core command kind: 1 = clear, 0 = send |
| cmd_msg | input | NUM_CORES*32 | Per-core message word; core s uses bits [s*32 +: 32] |
| id_we | input | 1 | Identity register write strobe |
| id_sel | input | IDX_W | Core whose identity register is written |
| id_wdata | input | 14 | New identity value |
| pend_norm | output | NUM_CORES | Normal doorbell pending bit per core |
| pend_crit | output | NUM_CORES | Critical doorbell pending bit per core |
| notify | output | NUM_CORES | One-cycle interrupt notification per core |

## Verification
Each core's pending bits drive the ports directly. A wrong internal bit therefore shows on pend_norm or pend_crit on the first cycle after the faulty command, and it stays visible until a later clear or send masks it. A corrupted identity register shows nothing by itself. It becomes visible only when a tag-addressed send reaches the wrong core, so every identity write is followed by a send that tests both the old value and the new one. Notify is a pulse, so a wrong notify is only visible during that one cycle, and it is sampled there.

// File: rtl/db_pkg.sv
package db_pkg;
    localparam int MSG_W     = 32;
    localparam int KIND_HI   = 31;
    localparam int KIND_LO   = 27;
    localparam int BCAST_BIT = 26;
    localparam int TAG_W     = 14;

    typedef enum logic [4:0] {
        KIND_NORMAL  = 5'd0,
        KIND_CRIT    = 5'd1,
        KIND_G_NORM  = 5'd2,
        KIND_G_CRIT  = 5'd3,
        KIND_G_MCHK  = 5'd4
    } db_kind_e;
endpackage

// File: rtl/db_decode.sv
module db_decode
    import db_pkg::*;
(
    input  logic [MSG_W-1:0] msg,
    output logic             is_norm,
    output logic             is_crit,
    output logic             bcast,
    output logic [TAG_W-1:0] tag
);
    logic       unused_mid;
    logic [4:0] kind;

    assign kind       = msg[KIND_HI:KIND_LO];
    assign bcast      = msg[BCAST_BIT];
    assign tag        = msg[TAG_W-1:0];
    assign unused_mid = ^msg[BCAST_BIT-1:TAG_W];

    always_comb begin
        is_norm = 1'b0;
        is_crit = 1'b0;
        case (kind)
            KIND_NORMAL: is_norm = 1'b1;
            KIND_CRIT:   is_crit = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/db_slot.sv
module db_slot
    import db_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int IDX       = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       id_wr,
    input  logic [TAG_W-1:0]           id_wdata,
    input  logic [NUM_CORES-1:0]       src_send,
    input  logic [NUM_CORES-1:0]       src_norm,
    input  logic [NUM_CORES-1:0]       src_crit,
    input  logic [NUM_CORES-1:0]       src_bcast,
    input  logic [NUM_CORES*TAG_W-1:0] src_tag,
    input  logic                       own_clear,
    output logic                       pend_norm,
    output logic                       pend_crit,
    output logic                       notify
);
    logic [TAG_W-1:0]     my_id_q;
    logic [NUM_CORES-1:0] hit_vec;
    logic                 hit_norm, hit_crit;
    logic                 clr_norm, clr_crit;
    logic                 pend_norm_q, pend_crit_q, notify_q;

    for (genvar s = 0; s < NUM_CORES; s++) begin : g_match
        assign hit_vec[s] = src_send[s] &&
                            (src_bcast[s] || (src_tag[s*TAG_W +: TAG_W] == my_id_q));
    end

    assign hit_norm = |(hit_vec & src_norm);
    assign hit_crit = |(hit_vec & src_crit);
    assign clr_norm = own_clear && src_norm[IDX];
    assign clr_crit = own_clear && src_crit[IDX];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            my_id_q     <= TAG_W'(IDX);
            pend_norm_q <= 1'b0;
            pend_crit_q <= 1'b0;
            notify_q    <= 1'b0;
        end else begin
            if (id_wr)
                my_id_q <= id_wdata;
            if (hit_norm)      pend_norm_q <= 1'b1;
            else if (clr_norm) pend_norm_q <= 1'b0;
            if (hit_crit)      pend_crit_q <= 1'b1;
            else if (clr_crit) pend_crit_q <= 1'b0;
            notify_q <= hit_norm || hit_crit;
        end
    end

    assign pend_norm = pend_norm_q;
    assign pend_crit = pend_crit_q;
    assign notify    = notify_q;

    AST_SEND_SETS_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        hit_norm |=> pend_norm_q);                                   // R2
    AST_SEND_SETS_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_crit |=> pend_crit_q);                                   // R2
    AST_SEND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_crit && clr_crit) |=> pend_crit_q);                     // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_norm && !hit_norm) |=> !pend_norm_q);                   // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_norm && !clr_norm) |=> $stable(pend_norm_q));          // R7
    AST_NOTIFY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_norm || hit_crit) |=> notify_q);                        // R5
    AST_NOTIFY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_norm || hit_crit) |=> !notify_q);                      // R5
endmodule

// File: rtl/db_router.sv
module db_router
    import db_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES-1:0]       cmd_valid,
    input  logic [NUM_CORES-1:0]       cmd_clear,
    input  logic [NUM_CORES*MSG_W-1:0] cmd_msg,
    input  logic                       id_we,
    input  logic [IDX_W-1:0]           id_sel,
    input  logic [TAG_W-1:0]           id_wdata,
    output logic [NUM_CORES-1:0]       pend_norm,
    output logic [NUM_CORES-1:0]       pend_crit,
    output logic [NUM_CORES-1:0]       notify
);
    logic [NUM_CORES-1:0]       d_norm, d_crit, d_bcast, d_send;
    logic [NUM_CORES*TAG_W-1:0] d_tag;

    assign d_send = cmd_valid & ~cmd_clear;

    for (genvar s = 0; s < NUM_CORES; s++) begin : g_dec
        db_decode u_dec (
            .msg     (cmd_msg[s*MSG_W +: MSG_W]),
            .is_norm (d_norm[s]),
            .is_crit (d_crit[s]),
            .bcast   (d_bcast[s]),
            .tag     (d_tag[s*TAG_W +: TAG_W])
        );
    end

    for (genvar t = 0; t < NUM_CORES; t++) begin : g_slot
        db_slot #(.NUM_CORES(NUM_CORES), .IDX(t)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .id_wr     (id_we && (id_sel == IDX_W'(t))),
            .id_wdata  (id_wdata),
            .src_send  (d_send),
            .src_norm  (d_norm),
            .src_crit  (d_crit),
            .src_bcast (d_bcast),
            .src_tag   (d_tag),
            .own_clear (cmd_valid[t] && cmd_clear[t]),
            .pend_norm (pend_norm[t]),
            .pend_crit (pend_crit[t]),
            .notify    (notify[t])
        );
    end

    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|(d_send & d_bcast & d_norm)) |=> (&pend_norm));            // R3
endmodule

// File: tb/test_db_router.sv
module test_db_router;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cmd_valid = '0;
    logic [N-1:0]  cmd_clear = '0;
    logic [N*32-1:0] cmd_msg = '0;
    logic          id_we = 1'b0;
    logic [1:0]    id_sel = '0;
    logic [13:0]   id_wdata = '0;
    logic [N-1:0]  pend_norm, pend_crit, notify;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    db_router #(.NUM_CORES(N)) i_db_router (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_clear(cmd_clear), .cmd_msg(cmd_msg),
        .id_we(id_we), .id_sel(id_sel), .id_wdata(id_wdata),
        .pend_norm(pend_norm), .pend_crit(pend_crit), .notify(notify)
    );

    function automatic logic [31:0] mk(input int kind, input bit bc, input int tag);
        return {5'(kind), bc, 12'h0, 14'(tag)};
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = '0;
        cmd_clear = '0;
        id_we     = 1'b0;
    endtask

    task automatic one(input int src, input bit clr, input logic [31:0] m);
        cmd_valid[src] = 1'b1;
        cmd_clear[src] = clr;
        cmd_msg[src*32 +: 32] = m;
        tick();
    endtask

    task automatic t_reset;
        chk("R1 norm", pend_norm, 4'b0000);
        chk("R1 crit", pend_crit, 4'b0000);
        chk("R1 notify", notify, 4'b0000);
        one(0, 0, mk(0, 0, 2));
        chk("R1/R4 reset id steers tag 2", pend_norm, 4'b0100);
        chk("R5 notify pulse", notify, 4'b0100);
        tick();
        chk("R5 notify drops", notify, 4'b0000);
    endtask

    task automatic t_crit;
        one(1, 0, mk(1, 0, 3));
        chk("R2 crit set", pend_crit, 4'b1000);
        chk("R2 norm untouched", pend_norm, 4'b0100);
    endtask

    task automatic t_bcast;
        one(3, 0, mk(0, 1, 14'h3FFF));
        chk("R3 bcast norm", pend_norm, 4'b1111);
        chk("R3 bcast notify", notify, 4'b1111);
    endtask

    task automatic t_clear;
        one(2, 1, mk(0, 0, 0));
        chk("R6 clear own norm", pend_norm, 4'b1011);
        chk("R6 crit kept", pend_crit, 4'b1000);
        chk("R6 clear no notify", notify, 4'b0000);
        one(3, 1, mk(1, 1, 0));
        chk("R6 clear crit ignores bcast", pend_crit, 4'b0000);
        chk("R6 norm kept", pend_norm, 4'b1011);
    endtask

    task automatic t_ignore;
        one(0, 0, mk(2, 1, 0));
        chk("R7 guest send norm", pend_norm, 4'b1011);
        chk("R7 guest send notify", notify, 4'b0000);
        one(1, 0, mk(31, 1, 0));
        chk("R7 unknown send crit", pend_crit, 4'b0000);
        chk("R7 unknown notify", notify, 4'b0000);
        one(0, 1, mk(3, 0, 0));
        chk("R7 guest clear", pend_norm, 4'b1011);
    endtask

    task automatic t_id;
        id_we = 1'b1; id_sel = 2'd1; id_wdata = 14'h1234;
        tick();
        one(0, 0, mk(1, 0, 1));
        chk("R8 old id misses", pend_crit, 4'b0000);
        one(0, 0, mk(1, 0, 14'h1234));
        chk("R8 new id hits", pend_crit, 4'b0010);
    endtask

    task automatic t_race;
        cmd_valid = 4'b0101;
        cmd_clear = 4'b0001;
        cmd_msg[0*32 +: 32] = mk(1, 0, 0);
        cmd_msg[2*32 +: 32] = mk(1, 0, 0);
        tick();
        chk("R9 send beats clear", pend_crit, 4'b0011);
        one(0, 1, mk(1, 0, 0));
        chk("R9 lone clear works", pend_crit, 4'b0010);
    endtask

    task automatic t_multi;
        cmd_valid = 4'b1011;
        cmd_clear = 4'b1011;
        cmd_msg[0*32 +: 32] = mk(0, 0, 0);
        cmd_msg[1*32 +: 32] = mk(0, 0, 0);
        cmd_msg[3*32 +: 32] = mk(0, 0, 0);
        tick();
        chk("R6 parallel clears", pend_norm, 4'b0000);
        cmd_valid = 4'b1001;
        cmd_clear = 4'b0000;
        cmd_msg[0*32 +: 32] = mk(0, 0, 2);
        cmd_msg[3*32 +: 32] = mk(0, 0, 14'h1234);
        tick();
        chk("R10 union norm", pend_norm, 4'b0110);
        chk("R10 union notify", notify, 4'b0110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_crit();
        t_bcast();
        t_clear();
        t_ignore();
        t_id();
        t_race();
        t_multi();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule